// File: doc/BRIEF.md
# Snooping MSI Coherence Controller

This block is the coherence controller that sits beside one core's direct-mapped cache in a small shared-bus multiprocessor. It keeps a tag and a three-valued line state (invalid, shared, modified) for every cache index. It serves two sources at once. The first is the local processor, whose reads and writes either complete at once or need a bus transaction. The second is the shared snoop bus, where the other controllers' read-miss, write-miss and invalidate transactions appear.

For a local miss or an ownership upgrade, the controller requests the bus from an external arbiter. Once granted, it drives exactly one transaction and then, for a miss, waits for the memory fill. When another core misses on a block this controller holds dirty, it intervenes: it supplies the block from its cache and tells memory to drop the fetch. A dirty block that is read remotely is also written back to memory and kept as shared.

The data array, the arbiter and memory live outside the block. An address splits into the index in its low `IDX_W` bits and the tag in the bits above them. The processor side runs on four named states:
- IDLE: decides hit or bus need. On a need it goes to ARB.
- ARB: holds the bus request. On a grant it goes to ISSUE.
- ISSUE: drives the transaction for one cycle. An upgrade goes back to IDLE and a miss goes to FILL.
- FILL: waits for the fill. When it arrives it goes to IDLE.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset every line is invalid: with no request `cpu_ready` is 1, and the first read of any address needs a bus read-miss.
- R2: A read whose index holds a different tag or an invalid line issues bus op 2'b01 (read-miss) with the request address. After `mem_fill_done` the line is shared, and the repeated read completes with no further bus traffic. A read of a shared or modified matching line completes with no traffic.
- R3: A write to a line that is invalid or holds another tag issues bus op 2'b10 (write-miss). After the fill the line is modified.
- R4: A write to a matching shared line issues bus op 2'b11 (invalidate) and needs no fill; the line becomes modified. A write to a matching modified line completes with no bus traffic.
- R5: A snooped invalidate (2'b11), or a write-miss (2'b10) that matches a valid shared line, makes that line invalid and drives no response.
- R6: A snooped read-miss (2'b01) that matches a modified line raises `snp_supply`, `mem_abort` and `mem_wb` in the same cycle as `snp_valid`, and the line becomes shared.
- R7: A snooped write-miss that matches a modified line raises `snp_supply` and `mem_abort` but not `mem_wb`, and the line becomes invalid.
- R8: A snooped transaction that matches no valid line, or a read-miss that matches a shared line, drives no response and changes no state.
- R9: `cpu_ready` is 0 while a bus request waits for a grant or a fill is outstanding. Snoops are still answered during such a stall.
- R10: `bus_valid` is high for exactly one cycle, and only in the cycle after one with both `bus_req` and `bus_gnt` high. `bus_req` is held until it is granted.
- R11: A pending upgrade whose shared line is invalidated by a snoop before the issue cycle is issued as a write-miss (2'b10) and then waits for a fill.
- R12: A miss whose index holds a modified line of another tag pulses `vic_wb` in the issue cycle, with `vic_addr` holding the victim's tag and the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until completed |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor block address |
| cpu_ready | output | 1 | Request completes this cycle (or idle); low while stalled |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_valid | output | 1 | Transaction on the bus this cycle |
| bus_op | output | 2 | 01 read-miss, 10 write-miss, 11 invalidate |
| bus_addr | output | ADDR_W | Transaction block address |
| mem_fill_done | input | 1 | Fill for the outstanding miss has arrived |
| vic_wb | output | 1 | Modified victim must be written back |
| vic_addr | output | ADDR_W | Victim block address |
| snp_valid | input | 1 | Snooped transaction present |
| snp_op | input | 2 | Snooped op, same encoding as bus_op |
| snp_addr | input | ADDR_W | Snooped block address |
| snp_supply | output | 1 | Intervention: this cache supplies the dirty block |
| mem_abort | output | 1 | Memory must cancel its fetch for this snoop |
| mem_wb | output | 1 | Memory must take the supplied block as a write-back |

## Verification
An exhaustive sweep of all three snoop ops over every address of an empty cache shows that no response or state comes from nothing. A long pseudo-random mix of reads, writes and snoops over three tags that share four indexes then drives every line through all its transitions, and is checked against a state model kept in the bench. The mix also varies the grant delay and injects snoops during stalls. This separates hit from miss from upgrade, supply with or without write-back, and a victim eviction from a plain fill. Directed cases then force the two interleavings that are easy to get wrong: an upgrade that is invalidated while it waits for the bus, and an intervention served while the processor is stalled.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'b00,
        LS_SHD = 2'b01,
        LS_MOD = 2'b10
    } line_st_t;

    typedef enum logic [1:0] {
        OP_NONE   = 2'b00,
        OP_RDMISS = 2'b01,
        OP_WRMISS = 2'b10,
        OP_INV    = 2'b11
    } bus_op_t;

    typedef enum logic [1:0] {
        C_IDLE,
        C_ARB,
        C_ISSUE,
        C_FILL
    } ctl_st_t;

endpackage

// File: rtl/coh_line_array.sv
module coh_line_array
    import coh_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    // processor-side port (read and write)
    input  logic [IDX_W-1:0] c_idx,
    output line_st_t         c_st,
    output logic [TAG_W-1:0] c_tag,
    input  logic             c_we,
    input  logic [TAG_W-1:0] c_wtag,
    input  line_st_t         c_wst,
    // snoop-side port (read, state write only)
    input  logic [IDX_W-1:0] s_idx,
    output line_st_t         s_st,
    output logic [TAG_W-1:0] s_tag,
    input  logic             s_we,
    input  line_st_t         s_wst
);
    localparam int LINES = 1 << IDX_W;

    line_st_t         st_arr  [LINES];
    logic [TAG_W-1:0] tag_arr [LINES];

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            line_st_t         st_r;
            logic [TAG_W-1:0] tag_r;
            // processor port has priority over the snoop port on the same line
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_r  <= LS_INV;
                    tag_r <= '0;
                end else if (c_we && (c_idx == IDX_W'(g))) begin
                    st_r  <= c_wst;
                    tag_r <= c_wtag;
                end else if (s_we && (s_idx == IDX_W'(g))) begin
                    st_r  <= s_wst;
                end
            end
            assign st_arr[g]  = st_r;
            assign tag_arr[g] = tag_r;
        end
    endgenerate

    assign c_st  = st_arr[c_idx];
    assign c_tag = tag_arr[c_idx];
    assign s_st  = st_arr[s_idx];
    assign s_tag = tag_arr[s_idx];

endmodule

// File: rtl/coh_snoop.sv
module coh_snoop
    import coh_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             snp_valid,
    input  bus_op_t          snp_op,
    input  logic [TAG_W-1:0] snp_tag,
    input  line_st_t         line_st,
    input  logic [TAG_W-1:0] line_tag,
    output logic             supply,
    output logic             abort,
    output logic             wb,
    output logic             s_we,
    output line_st_t         s_wst
);
    logic match;

    assign match = snp_valid && (line_st != LS_INV) && (line_tag == snp_tag);

    always_comb begin
        supply = 1'b0;
        wb     = 1'b0;
        s_we   = 1'b0;
        s_wst  = line_st;
        if (match) begin
            unique case (snp_op)
                OP_RDMISS: begin
                    if (line_st == LS_MOD) begin
                        supply = 1'b1;
                        wb     = 1'b1;
                        s_we   = 1'b1;
                        s_wst  = LS_SHD;
                    end
                end
                OP_WRMISS: begin
                    supply = (line_st == LS_MOD);
                    s_we   = 1'b1;
                    s_wst  = LS_INV;
                end
                OP_INV: begin
                    s_we  = 1'b1;
                    s_wst = LS_INV;
                end
                default: ;
            endcase
        end
    end

    // memory fetch is cancelled whenever this cache intervenes
    assign abort = supply;

endmodule

// File: rtl/coh_ctl_fsm.sv
module coh_ctl_fsm
    import coh_pkg::*;
#(
    parameter  int ADDR_W = 6,
    parameter  int IDX_W  = 2,
    localparam int TAG_W  = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    // line-array processor port
    output logic [IDX_W-1:0]  c_idx,
    input  line_st_t          l_st,
    input  logic [TAG_W-1:0]  l_tag,
    output logic              c_we,
    output logic [TAG_W-1:0]  c_wtag,
    output line_st_t          c_wst,
    // bus side
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_valid,
    output bus_op_t           bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              mem_fill_done,
    output logic              vic_wb,
    output logic [ADDR_W-1:0] vic_addr
);
    ctl_st_t           state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              we_q;
    bus_op_t           op_q;

    logic [ADDR_W-1:0] cur_addr;
    logic [TAG_W-1:0]  cur_tag;
    logic              line_hit;
    bus_op_t           need_op;
    bus_op_t           eff_op;

    assign cur_addr = (state_q == C_IDLE) ? cpu_addr : addr_q;
    assign c_idx    = cur_addr[IDX_W-1:0];
    assign cur_tag  = cur_addr[ADDR_W-1:IDX_W];
    assign line_hit = (l_st != LS_INV) && (l_tag == cur_tag);

    // bus work needed by the presented request
    always_comb begin
        if (!cpu_we)
            need_op = line_hit ? OP_NONE : OP_RDMISS;
        else if (line_hit && (l_st == LS_MOD))
            need_op = OP_NONE;
        else if (line_hit)
            need_op = OP_INV;
        else
            need_op = OP_WRMISS;
    end

    // an upgrade that lost its shared copy while waiting becomes a write-miss
    assign eff_op = ((op_q == OP_INV) && !line_hit) ? OP_WRMISS : op_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_IDLE:  if (cpu_req && (need_op != OP_NONE)) state_d = C_ARB;
            C_ARB:   if (bus_gnt) state_d = C_ISSUE;
            C_ISSUE: state_d = (eff_op == OP_INV) ? C_IDLE : C_FILL;
            C_FILL:  if (mem_fill_done) state_d = C_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= C_IDLE;
            addr_q  <= '0;
            we_q    <= 1'b0;
            op_q    <= OP_NONE;
        end else begin
            state_q <= state_d;
            if ((state_q == C_IDLE) && (state_d == C_ARB)) begin
                addr_q <= cpu_addr;
                we_q   <= cpu_we;
                op_q   <= need_op;
            end
        end
    end

    always_comb begin
        cpu_ready = 1'b0;
        bus_req   = 1'b0;
        bus_valid = 1'b0;
        bus_op    = OP_NONE;
        bus_addr  = addr_q;
        vic_wb    = 1'b0;
        vic_addr  = {l_tag, addr_q[IDX_W-1:0]};
        c_we      = 1'b0;
        c_wtag    = cur_tag;
        c_wst     = LS_INV;
        unique case (state_q)
            C_IDLE: begin
                cpu_ready = !(cpu_req && (need_op != OP_NONE));
            end
            C_ARB: begin
                bus_req = 1'b1;
            end
            C_ISSUE: begin
                bus_valid = 1'b1;
                bus_op    = eff_op;
                c_we      = 1'b1;
                if (eff_op == OP_INV) begin
                    c_wst = LS_MOD;
                end else begin
                    // victim leaves the line; fill installs the new block later
                    c_wtag = l_tag;
                    c_wst  = LS_INV;
                    vic_wb = (l_st == LS_MOD) && (l_tag != cur_tag);
                end
            end
            C_FILL: begin
                if (mem_fill_done) begin
                    c_we  = 1'b1;
                    c_wst = we_q ? LS_MOD : LS_SHD;
                end
            end
        endcase
    end

endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl
    import coh_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_valid,
    output logic [1:0]        bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              mem_fill_done,
    output logic              vic_wb,
    output logic [ADDR_W-1:0] vic_addr,
    input  logic              snp_valid,
    input  logic [1:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_supply,
    output logic              mem_abort,
    output logic              mem_wb
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0] c_idx;
    line_st_t         c_st, c_wst, s_st, s_wst;
    logic [TAG_W-1:0] c_tag, c_wtag, s_tag;
    logic             c_we, s_we;
    bus_op_t          bus_op_e;

    coh_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_lines (
        .clk    (clk),
        .rst_n  (rst_n),
        .c_idx  (c_idx),
        .c_st   (c_st),
        .c_tag  (c_tag),
        .c_we   (c_we),
        .c_wtag (c_wtag),
        .c_wst  (c_wst),
        .s_idx  (snp_addr[IDX_W-1:0]),
        .s_st   (s_st),
        .s_tag  (s_tag),
        .s_we   (s_we),
        .s_wst  (s_wst)
    );

    coh_snoop #(.TAG_W(TAG_W)) u_snoop (
        .snp_valid (snp_valid),
        .snp_op    (bus_op_t'(snp_op)),
        .snp_tag   (snp_addr[ADDR_W-1:IDX_W]),
        .line_st   (s_st),
        .line_tag  (s_tag),
        .supply    (snp_supply),
        .abort     (mem_abort),
        .wb        (mem_wb),
        .s_we      (s_we),
        .s_wst     (s_wst)
    );

    coh_ctl_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_req       (cpu_req),
        .cpu_we        (cpu_we),
        .cpu_addr      (cpu_addr),
        .cpu_ready     (cpu_ready),
        .c_idx         (c_idx),
        .l_st          (c_st),
        .l_tag         (c_tag),
        .c_we          (c_we),
        .c_wtag        (c_wtag),
        .c_wst         (c_wst),
        .bus_req       (bus_req),
        .bus_gnt       (bus_gnt),
        .bus_valid     (bus_valid),
        .bus_op        (bus_op_e),
        .bus_addr      (bus_addr),
        .mem_fill_done (mem_fill_done),
        .vic_wb        (vic_wb),
        .vic_addr      (vic_addr)
    );

    assign bus_op = bus_op_e;

endmodule

// File: rtl/coh_ctl_checker.sv
module coh_ctl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_ready,
    input logic       bus_req,
    input logic       bus_gnt,
    input logic       bus_valid,
    input logic [1:0] bus_op,
    input logic       vic_wb,
    input logic       snp_valid,
    input logic [1:0] snp_op,
    input logic       snp_supply,
    input logic       mem_abort,
    input logic       mem_wb
);
    assert_issue_after_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> $past(bus_req && bus_gnt));

    assert_issue_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> !bus_valid);

    assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);

    assert_stall_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !cpu_ready);

    assert_supply_needs_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> (snp_valid && (snp_op == 2'b01 || snp_op == 2'b10) && mem_abort));

    assert_wb_only_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wb |-> (snp_supply && snp_op == 2'b01));

    assert_victim_on_miss_R12: assert property (@(posedge clk) disable iff (!rst_n)
        vic_wb |-> (bus_valid && bus_op != 2'b11));

endmodule

bind snoop_coh_ctrl coh_ctl_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_ready  (cpu_ready),
    .bus_req    (bus_req),
    .bus_gnt    (bus_gnt),
    .bus_valid  (bus_valid),
    .bus_op     (bus_op),
    .vic_wb     (vic_wb),
    .snp_valid  (snp_valid),
    .snp_op     (snp_op),
    .snp_supply (snp_supply),
    .mem_abort  (mem_abort),
    .mem_wb     (mem_wb)
);

// File: tb/snoop_coh_ctrl_bench.sv
`timescale 1ns/1ps
module snoop_coh_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req = 1'b0, cpu_we = 1'b0;
    logic [5:0] cpu_addr = '0;
    logic       cpu_ready;
    logic       bus_req, bus_gnt = 1'b0, bus_valid;
    logic [1:0] bus_op;
    logic [5:0] bus_addr;
    logic       mem_fill_done = 1'b0;
    logic       vic_wb;
    logic [5:0] vic_addr;
    logic       snp_valid = 1'b0;
    logic [1:0] snp_op = '0;
    logic [5:0] snp_addr = '0;
    logic       snp_supply, mem_abort, mem_wb;

    int nvec = 0;
    int nerr = 0;
    int last_nis;
    // model: 0 invalid, 1 shared, 2 modified
    int         m_st  [4];
    logic [3:0] m_tag [4];
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    snoop_coh_ctrl u_snoop_coh_ctrl (.*);

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic snoop_check(input logic [1:0] op, input logic [5:0] a);
        int i;
        logic hit, es, ew;
        string rq;
        i = int'(a[1:0]);
        hit = (m_st[i] != 0) && (m_tag[i] == a[5:2]);
        es = 1'b0; ew = 1'b0; rq = "R8";
        if (hit) begin
            if (op == 2'b01) begin
                if (m_st[i] == 2) begin es = 1'b1; ew = 1'b1; m_st[i] = 1; rq = "R6"; end
            end else if (op == 2'b10) begin
                if (m_st[i] == 2) begin es = 1'b1; rq = "R7"; end else rq = "R5";
                m_st[i] = 0;
            end else if (op == 2'b11) begin
                m_st[i] = 0; rq = "R5";
            end
        end
        chk(rq, "snp_supply", snp_supply, es);
        chk(rq, "mem_abort",  mem_abort,  es);
        chk(rq, "mem_wb",     mem_wb,     ew);
    endtask

    task automatic snoop_only(input logic [1:0] op, input logic [5:0] a);
        @(posedge clk); #1;
        snp_valid = 1'b1; snp_op = op; snp_addr = a;
        @(negedge clk);
        snoop_check(op, a);
        @(posedge clk); #1;
        snp_valid = 1'b0;
    endtask

    task automatic access(input logic we, input logic [5:0] a, input int gdly,
                          input logic inj, input logic [1:0] sop, input logic [5:0] sa);
        int i, nis, waitc, fcnt, guard, eop;
        logic need, start_shd, injected, stallbad, early, gnt_given, br, evic;
        string rq;
        i = int'(a[1:0]);
        start_shd = (m_st[i] == 1) && (m_tag[i] == a[5:2]);
        need = we ? !((m_st[i] == 2) && (m_tag[i] == a[5:2]))
                  : !((m_st[i] != 0) && (m_tag[i] == a[5:2]));
        rq = we ? ((start_shd || !need) ? "R4" : "R3") : "R2";
        nis = 0; waitc = 0; fcnt = 0; guard = 0;
        injected = 1'b0; stallbad = 1'b0; early = 1'b0; gnt_given = 1'b0;
        @(posedge clk); #1;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a;
        forever begin
            @(negedge clk);
            br = bus_req;
            if (cpu_ready && (bus_req || bus_valid || fcnt > 0 || mem_fill_done)) stallbad = 1'b1;
            if (cpu_ready) break;
            if (snp_valid) snoop_check(snp_op, snp_addr);
            if (bus_valid) begin
                nis++;
                if (!gnt_given) early = 1'b1;
                if (!we) eop = 1;
                else eop = ((m_st[i] == 1) && (m_tag[i] == a[5:2])) ? 3 : 2;
                chk((we && start_shd && eop == 2) ? "R11" : rq, "bus_op", bus_op, eop);
                chk(rq, "bus_addr", bus_addr, a);
                evic = (eop != 3) && (m_st[i] == 2) && (m_tag[i] != a[5:2]);
                chk("R12", "vic_wb", vic_wb, evic);
                if (evic) chk("R12", "vic_addr", vic_addr, {m_tag[i], a[1:0]});
                if (eop != 3) begin m_st[i] = 0; fcnt = 2; end
            end
            guard++;
            if (guard > 100) begin
                chk("R9", "access completes", 0, 1);
                break;
            end
            @(posedge clk); #1;
            snp_valid = 1'b0;
            if (inj && !injected && br) begin
                snp_valid = 1'b1; snp_op = sop; snp_addr = sa; injected = 1'b1;
            end
            bus_gnt = 1'b0;
            if (br) begin
                if (waitc >= gdly) begin bus_gnt = 1'b1; gnt_given = 1'b1; end
                waitc++;
            end
            mem_fill_done = 1'b0;
            if (fcnt > 0) begin
                fcnt--;
                mem_fill_done = (fcnt == 0);
            end
        end
        chk("R9", "ready only with bus and fill idle", stallbad, 0);
        chk("R10", "issue before grant", early, 0);
        chk(rq, "bus transactions", nis, need ? 1 : 0);
        last_nis = nis;
        if (we) m_st[i] = 2;
        else if (!((m_st[i] != 0) && (m_tag[i] == a[5:2]))) m_st[i] = 1;
        m_tag[i] = a[5:2];
        @(posedge clk); #1;
        cpu_req = 1'b0; bus_gnt = 1'b0; snp_valid = 1'b0; mem_fill_done = 1'b0;
    endtask

    function automatic logic [15:0] step(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) begin m_st[k] = 0; m_tag[k] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "cpu_ready at reset", cpu_ready, 1);
        chk("R1", "bus_req at reset",   bus_req,   0);
        chk("R1", "bus_valid at reset", bus_valid, 0);

        // every address, every op, on an empty cache
        for (int a = 0; a < 64; a++)
            for (int op = 1; op < 4; op++)
                snoop_only(2'(op), 6'(a));

        // first reads all miss
        for (int k = 0; k < 4; k++) begin
            access(1'b0, 6'(k), 0, 1'b0, 2'b00, 6'd0);
            chk("R1", "first read misses", last_nis, 1);
        end

        // pseudo-random mix over 3 tags x 4 indexes
        for (int n = 0; n < 700; n++) begin
            logic [5:0] a, sa;
            logic [1:0] sop;
            lfsr = step(lfsr);
            a   = {2'b00, 2'(int'(lfsr[5:4]) % 3), lfsr[3:2]};
            sa  = {2'b00, 2'(int'(lfsr[12:11]) % 3), lfsr[14:13]};
            sop = 2'(1 + int'(lfsr[7:6]) % 3);
            unique case (lfsr[1:0])
                2'd0: access(1'b0, a, int'(lfsr[9:8]), lfsr[10], sop, sa);
                2'd1: access(1'b1, a, int'(lfsr[9:8]), lfsr[10], sop, sa);
                default: snoop_only(sop, a);
            endcase
        end

        // R11: upgrade loses its shared copy while waiting for the grant
        access(1'b0, 6'h25, 0, 1'b0, 2'b00, 6'd0);
        access(1'b1, 6'h25, 3, 1'b1, 2'b11, 6'h25);
        chk("R11", "upgrade completed as miss", m_st[1], 2);

        // R12: modified victim evicted by a read of another tag
        access(1'b1, 6'h02, 0, 1'b0, 2'b00, 6'd0);
        access(1'b0, 6'h06, 0, 1'b0, 2'b00, 6'd0);

        // R9: intervention served while the processor stalls on a miss
        access(1'b1, 6'h03, 0, 1'b0, 2'b00, 6'd0);
        access(1'b0, 6'h30, 4, 1'b1, 2'b01, 6'h03);
        chk("R9", "line 3 demoted during stall", m_st[3], 1);
        access(1'b1, 6'h03, 0, 1'b0, 2'b00, 6'd0);
        chk("R6", "write after demotion upgrades", last_nis, 1);

        // R7: write-miss snoop on a modified line
        snoop_only(2'b10, 6'h03);
        access(1'b0, 6'h03, 0, 1'b0, 2'b00, 6'd0);
        chk("R7", "read after steal misses", last_nis, 1);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule